// File: doc/BRIEF.md
# Mode-Multiplexed Address/GPIO Port

This block controls one 8-bit parallel port. Each of its pins does one of three things. It can carry a line of the internal address bus out of the chip, it can drive a bit of a software-written output register, or it can be an input. The operating mode number and an expansion-enable input choose the overall pin function. In some modes a per-bit direction register then makes the choice for each pin. Standby inputs can also override the choice.

Software reaches four byte-wide registers through a simple register bus:

- a write-only direction register;
- an output data register;
- a read-only pin level register;
- a pull-up request register.

Writes take effect on the clock edge that samples the write strobe. Reads are combinational.

The block drives per-pin value and output-enable signals toward the pad ring. It takes the pad input levels back and passes them through a synchronizer. It also computes a per-pin pull-up enable.

Top module: `addr_gpio_port`

## Requirements
- R1: After reset, the direction, output data and pull-up registers are all 0x00. So in mode 7 with expansion disabled, every pin output enable is low and both the data and pull-up registers read 0x00.
- R2: The registers are decoded at these 16-bit addresses: direction 0xFE2A, output data 0xFF6A, pin level 0xFF5A and pull-up 0xFE37. A write updates its register at the clock edge where the strobe is high. The data and pull-up registers read back what was written.
- R3: A read of the direction address returns 0xFF. A read of any unmapped address returns 0x00.
- R4: In modes 1, 2, 5 and 6, all eight pins drive the matching internal address bit, with output enable high, whatever the direction register holds.
- R5: In mode 4, and in mode 7 with expansion enabled, a pin whose direction bit is 1 drives its internal address bit. A pin whose direction bit is 0 is an input.
- R6: In mode 7 with expansion disabled, a pin whose direction bit is 1 drives its output data bit. A pin whose direction bit is 0 is an input.
- R7: In modes 0 and 3, every pin is an input.
- R8: While hardware standby is high, every output enable is low, the direction register is held at 0x00 and direction writes are ignored. The register stays 0x00 after standby ends.
- R9: Software standby leaves the direction register unchanged, and pins in output-data mode keep driving their data bit.
- R10: In software standby, each pin in address mode behaves according to the hold input. With hold high, the pin keeps driving the address value of the last cycle before standby. With hold low, its output enable is low.
- R11: The pin level register returns the driven value for pins whose output enable is high. For the other pins it returns the pad input after two clock edges of synchronization.
- R12: The pull-up enable of a pin is high exactly when its pull-up register bit is 1 and its output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | Operating mode number |
| expand_en_i | input | 1 | Expansion enable; selects address mode in mode 7 |
| int_addr_i | input | 8 | Internal address bits for the port pins |
| hw_stby_i | input | 1 | Hardware standby |
| sw_stby_i | input | 1 | Software standby |
| hold_out_i | input | 1 | Keep address pins driven during software standby |
| bus_addr_i | input | 16 | Register bus address |
| bus_wr_i | input | 1 | Register write strobe |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data (combinational) |
| pin_in_i | input | 8 | Pad input levels |
| pin_out_o | output | 8 | Pad drive values |
| pin_oe_o | output | 8 | Pad output enables |
| pull_en_o | output | 8 | Pull-up enables |

## Verification
The bench sets the direction register to a split pattern: the low nibble is output and the high nibble is input. It then runs every mode with that pattern. In mode 4, mode 7 with expansion, and mode 7 without it, the output enables should follow the nibble. The driven value separates address from data because the internal address and the data register hold different patterns. All eight values of the mode number are tried, so forced-address modes and all-input modes are told apart from direction-controlled modes. The standby tests change the internal address after standby is entered. This shows whether held pins keep the last value from before standby or follow the bus. A pad input change is read back edge by edge to pin down the synchronizer delay.

// File: rtl/agp_pkg.sv
package agp_pkg;

    localparam int PORT_W = 8;
    localparam int BUS_AW = 16;
    localparam int MODE_W = 3;

    localparam logic [BUS_AW-1:0] ADR_DIR  = 16'hFE2A;
    localparam logic [BUS_AW-1:0] ADR_OUT  = 16'hFF6A;
    localparam logic [BUS_AW-1:0] ADR_PIN  = 16'hFF5A;
    localparam logic [BUS_AW-1:0] ADR_PULL = 16'hFE37;

    localparam logic [PORT_W-1:0] DIR_READ_VALUE = '1;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DIR,
        SEL_OUT,
        SEL_PIN,
        SEL_PULL
    } reg_sel_e;

    typedef enum logic [1:0] {
        PM_ALL_INPUT,
        PM_ADDR_ALL,
        PM_ADDR_DIR,
        PM_GPIO
    } port_mode_e;

    typedef struct packed {
        logic [PORT_W-1:0] dir;
        logic [PORT_W-1:0] outd;
        logic [PORT_W-1:0] pull;
    } port_regs_t;

    typedef struct packed {
        logic [PORT_W-1:0] oe;
        logic [PORT_W-1:0] val;
    } pin_drive_t;

    function automatic port_mode_e decode_mode(logic [MODE_W-1:0] m, logic expand);
        port_mode_e pm;
        case (m)
            3'd1, 3'd2, 3'd5, 3'd6: pm = PM_ADDR_ALL;
            3'd4:                   pm = PM_ADDR_DIR;
            3'd7:                   pm = expand ? PM_ADDR_DIR : PM_GPIO;
            default:                pm = PM_ALL_INPUT;
        endcase
        return pm;
    endfunction

    function automatic reg_sel_e decode_addr(logic [BUS_AW-1:0] a);
        reg_sel_e s;
        case (a)
            ADR_DIR:  s = SEL_DIR;
            ADR_OUT:  s = SEL_OUT;
            ADR_PIN:  s = SEL_PIN;
            ADR_PULL: s = SEL_PULL;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/agp_regs.sv
module agp_regs
    import agp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hw_stby_i,
    input  logic              wr_i,
    input  reg_sel_e          sel_i,
    input  logic [PORT_W-1:0] wdata_i,
    output port_regs_t        regs_o
);

    port_regs_t regs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            if (hw_stby_i) begin
                regs_q.dir <= '0;
            end else if (wr_i && sel_i == SEL_DIR) begin
                regs_q.dir <= wdata_i;
            end
            if (wr_i && sel_i == SEL_OUT) begin
                regs_q.outd <= wdata_i;
            end
            if (wr_i && sel_i == SEL_PULL) begin
                regs_q.pull <= wdata_i;
            end
        end
    end

    assign regs_o = regs_q;

endmodule

// File: rtl/agp_sync.sv
module agp_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= d_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= '0;
            else     stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/agp_pin_ctrl.sv
module agp_pin_ctrl
    import agp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              expand_en_i,
    input  logic [PORT_W-1:0] int_addr_i,
    input  logic              hw_stby_i,
    input  logic              sw_stby_i,
    input  logic              hold_out_i,
    input  port_regs_t        regs_i,
    output pin_drive_t        drive_o,
    output logic [PORT_W-1:0] pull_en_o
);

    port_mode_e        pmode;
    logic [PORT_W-1:0] last_addr_q;
    logic [PORT_W-1:0] addr_sel;
    logic [PORT_W-1:0] data_sel;

    assign pmode = decode_mode(mode_i, expand_en_i);

    // Address value seen on the last cycle outside software standby
    always_ff @(posedge clk) begin
        if (rst)             last_addr_q <= '0;
        else if (!sw_stby_i) last_addr_q <= int_addr_i;
    end

    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        assign addr_sel[i] = (pmode == PM_ADDR_ALL) ||
                             (pmode == PM_ADDR_DIR && regs_i.dir[i]);
        assign data_sel[i] = (pmode == PM_GPIO) && regs_i.dir[i];

        always_comb begin
            drive_o.oe[i]  = 1'b0;
            drive_o.val[i] = 1'b0;
            if (hw_stby_i) begin
                drive_o.oe[i]  = 1'b0;
            end else if (addr_sel[i]) begin
                if (sw_stby_i) begin
                    drive_o.oe[i]  = hold_out_i;
                    drive_o.val[i] = last_addr_q[i];
                end else begin
                    drive_o.oe[i]  = 1'b1;
                    drive_o.val[i] = int_addr_i[i];
                end
            end else if (data_sel[i]) begin
                drive_o.oe[i]  = 1'b1;
                drive_o.val[i] = regs_i.outd[i];
            end
        end

        assign pull_en_o[i] = regs_i.pull[i] & ~drive_o.oe[i];
    end

endmodule

// File: rtl/addr_gpio_port.sv
module addr_gpio_port
    import agp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              expand_en_i,
    input  logic [PORT_W-1:0] int_addr_i,
    input  logic              hw_stby_i,
    input  logic              sw_stby_i,
    input  logic              hold_out_i,
    input  logic [BUS_AW-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic [PORT_W-1:0] bus_wdata_i,
    output logic [PORT_W-1:0] bus_rdata_o,
    input  logic [PORT_W-1:0] pin_in_i,
    output logic [PORT_W-1:0] pin_out_o,
    output logic [PORT_W-1:0] pin_oe_o,
    output logic [PORT_W-1:0] pull_en_o
);

    reg_sel_e          sel;
    port_regs_t        regs;
    pin_drive_t        drive;
    logic [PORT_W-1:0] pin_sync;
    logic [PORT_W-1:0] level;
    logic [PORT_W-1:0] dir_q;

    assign sel   = decode_addr(bus_addr_i);
    assign dir_q = regs.dir;

    agp_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .hw_stby_i (hw_stby_i),
        .wr_i      (bus_wr_i),
        .sel_i     (sel),
        .wdata_i   (bus_wdata_i),
        .regs_o    (regs)
    );

    agp_sync #(
        .WIDTH  (PORT_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (pin_in_i),
        .q_o (pin_sync)
    );

    agp_pin_ctrl u_pins (
        .clk         (clk),
        .rst         (rst),
        .mode_i      (mode_i),
        .expand_en_i (expand_en_i),
        .int_addr_i  (int_addr_i),
        .hw_stby_i   (hw_stby_i),
        .sw_stby_i   (sw_stby_i),
        .hold_out_i  (hold_out_i),
        .regs_i      (regs),
        .drive_o     (drive),
        .pull_en_o   (pull_en_o)
    );

    assign level = (drive.oe & drive.val) | (~drive.oe & pin_sync);

    always_comb begin
        case (sel)
            SEL_DIR:  bus_rdata_o = DIR_READ_VALUE;
            SEL_OUT:  bus_rdata_o = regs.outd;
            SEL_PIN:  bus_rdata_o = level;
            SEL_PULL: bus_rdata_o = regs.pull;
            default:  bus_rdata_o = '0;
        endcase
    end

    assign pin_out_o = drive.val;
    assign pin_oe_o  = drive.oe;

endmodule

// File: rtl/agp_checker.sv
module agp_checker
    import agp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [MODE_W-1:0] mode_i,
    input logic              hw_stby_i,
    input logic              sw_stby_i,
    input logic              hold_out_i,
    input logic [PORT_W-1:0] int_addr_i,
    input logic [BUS_AW-1:0] bus_addr_i,
    input logic [PORT_W-1:0] bus_rdata_o,
    input logic [PORT_W-1:0] pin_out_o,
    input logic [PORT_W-1:0] pin_oe_o,
    input logic [PORT_W-1:0] pull_en_o,
    input logic [PORT_W-1:0] dir_q
);

    logic forced;
    assign forced = (mode_i == 3'd1) || (mode_i == 3'd2) ||
                    (mode_i == 3'd5) || (mode_i == 3'd6);

    AST_DIR_READS_ONES: assert property (@(posedge clk) disable iff (rst)
        bus_addr_i == ADR_DIR |-> bus_rdata_o == DIR_READ_VALUE); // R3

    AST_FORCED_ADDR_OUT: assert property (@(posedge clk) disable iff (rst)
        forced && !hw_stby_i && !sw_stby_i |->
            pin_oe_o == '1 && pin_out_o == int_addr_i); // R4

    AST_HWSTBY_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        hw_stby_i |-> pin_oe_o == '0); // R8

    AST_HWSTBY_DIR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        hw_stby_i |=> dir_q == '0); // R8

    AST_SWSTBY_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        forced && sw_stby_i && hold_out_i && !hw_stby_i &&
        $past(forced) && $past(sw_stby_i) && $past(hold_out_i) && !$past(hw_stby_i)
            |-> $stable(pin_out_o) && pin_oe_o == '1); // R10

    AST_SWSTBY_FLOAT: assert property (@(posedge clk) disable iff (rst)
        forced && sw_stby_i && !hold_out_i |-> pin_oe_o == '0); // R10

    AST_PULL_ONLY_INPUT: assert property (@(posedge clk) disable iff (rst)
        (pull_en_o & pin_oe_o) == '0); // R12

endmodule

bind addr_gpio_port agp_checker u_agp_checker (
    .clk         (clk),
    .rst         (rst),
    .mode_i      (mode_i),
    .hw_stby_i   (hw_stby_i),
    .sw_stby_i   (sw_stby_i),
    .hold_out_i  (hold_out_i),
    .int_addr_i  (int_addr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_rdata_o (bus_rdata_o),
    .pin_out_o   (pin_out_o),
    .pin_oe_o    (pin_oe_o),
    .pull_en_o   (pull_en_o),
    .dir_q       (dir_q)
);

// File: tb/test_addr_gpio_port.sv
module test_addr_gpio_port;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  mode_i = 3'd7;
    logic        expand_en_i = 1'b0;
    logic [7:0]  int_addr_i = 8'h00;
    logic        hw_stby_i = 1'b0;
    logic        sw_stby_i = 1'b0;
    logic        hold_out_i = 1'b0;
    logic [15:0] bus_addr_i = 16'h0000;
    logic        bus_wr_i = 1'b0;
    logic [7:0]  bus_wdata_i = 8'h00;
    logic [7:0]  bus_rdata_o;
    logic [7:0]  pin_in_i = 8'h00;
    logic [7:0]  pin_out_o;
    logic [7:0]  pin_oe_o;
    logic [7:0]  pull_en_o;

    always #2 clk = ~clk;

    addr_gpio_port i_addr_gpio_port (
        .clk         (clk),
        .rst         (rst),
        .mode_i      (mode_i),
        .expand_en_i (expand_en_i),
        .int_addr_i  (int_addr_i),
        .hw_stby_i   (hw_stby_i),
        .sw_stby_i   (sw_stby_i),
        .hold_out_i  (hold_out_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wr_i    (bus_wr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .pin_in_i    (pin_in_i),
        .pin_out_o   (pin_out_o),
        .pin_oe_o    (pin_oe_o),
        .pull_en_o   (pull_en_o)
    );

    localparam logic [15:0] A_DIR  = 16'hFE2A;
    localparam logic [15:0] A_OUT  = 16'hFF6A;
    localparam logic [15:0] A_PIN  = 16'hFF5A;
    localparam logic [15:0] A_PULL = 16'hFE37;

    // what: 0 output enables, 1 driven value under enable, 2 read data, 3 pull-ups
    typedef struct {
        string      req;
        int         what;
        logic [7:0] exp;
    } exp_item_t;

    exp_item_t exp_q[$];
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    task automatic expect_out(input string req, input int what, input logic [7:0] exp);
        exp_item_t it;
        it.req = req; it.what = what; it.exp = exp;
        exp_q.push_back(it);
        wait (exp_q.size() == 0);
    endtask

    initial begin : monitor
        forever begin
            exp_item_t it;
            logic [7:0] act;
            wait (exp_q.size() != 0);
            it = exp_q[0];
            case (it.what)
                0:       act = pin_oe_o;
                1:       act = pin_out_o & pin_oe_o;
                2:       act = bus_rdata_o;
                default: act = pull_en_o;
            endcase
            n_tests++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.what, act, it.exp);
            end
            void'(exp_q.pop_front());
        end
    end

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
        @(negedge clk);
        bus_wr_i = 1'b0;
    endtask

    task automatic read_check(input string req, input logic [15:0] a, input logic [7:0] exp);
        bus_addr_i = a;
        #1;
        expect_out(req, 2, exp);
    endtask

    initial begin : watchdog
        #(4 * 100000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL WATCHDOG run did not finish actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset values
        expect_out("R1", 0, 8'h00);
        read_check("R1", A_OUT, 8'h00);
        read_check("R1", A_PULL, 8'h00);
        // R3: direction reads ones, unmapped reads zero
        read_check("R3", A_DIR, 8'hFF);
        read_check("R3", 16'h1234, 8'h00);
        // R2: writes and read-back
        bus_write(A_OUT, 8'hA5);
        read_check("R2", A_OUT, 8'hA5);
        bus_write(A_PULL, 8'h3C);
        read_check("R2", A_PULL, 8'h3C);
        // R6: data output mode, low nibble output
        bus_write(A_DIR, 8'h0F);
        #1;
        expect_out("R6", 0, 8'h0F);
        expect_out("R6", 1, 8'h05);
        expect_out("R12", 3, 8'h30);
        // R11: synchronized inputs and driven outputs
        pin_in_i = 8'h90;
        repeat (3) @(negedge clk);
        read_check("R11", A_PIN, 8'h95);
        pin_in_i = 8'h60;
        #1;
        read_check("R11", A_PIN, 8'h95);
        @(negedge clk);
        read_check("R11", A_PIN, 8'h95);
        @(negedge clk);
        read_check("R11", A_PIN, 8'h65);
        // R5: direction-selected address output
        int_addr_i = 8'hC3;
        mode_i = 3'd4;
        #1;
        expect_out("R5", 0, 8'h0F);
        expect_out("R5", 1, 8'h03);
        read_check("R11", A_PIN, 8'h63);
        mode_i = 3'd7; expand_en_i = 1'b1;
        #1;
        expect_out("R5", 0, 8'h0F);
        expect_out("R5", 1, 8'h03);
        expand_en_i = 1'b0;
        // R4: forced address modes
        for (int m = 1; m <= 6; m++) begin
            if (m == 3 || m == 4) continue;
            mode_i = 3'(m);
            #1;
            expect_out("R4", 0, 8'hFF);
            expect_out("R4", 1, 8'hC3);
            expect_out("R12", 3, 8'h00);
        end
        // R7: all-input modes
        mode_i = 3'd0;
        #1;
        expect_out("R7", 0, 8'h00);
        mode_i = 3'd3;
        #1;
        expect_out("R7", 0, 8'h00);
        expect_out("R12", 3, 8'h3C);
        // R10: software standby hold and float
        @(negedge clk);
        mode_i = 3'd5; int_addr_i = 8'h5A;
        @(negedge clk);
        sw_stby_i = 1'b1; hold_out_i = 1'b1; int_addr_i = 8'h11;
        #1;
        expect_out("R10", 0, 8'hFF);
        expect_out("R10", 1, 8'h5A);
        @(negedge clk);
        expect_out("R10", 1, 8'h5A);
        hold_out_i = 1'b0;
        #1;
        expect_out("R10", 0, 8'h00);
        // R9: direction kept, data pins still driven
        mode_i = 3'd7;
        @(negedge clk);
        expect_out("R9", 0, 8'h0F);
        expect_out("R9", 1, 8'h05);
        sw_stby_i = 1'b0;
        // R8: hardware standby
        @(negedge clk);
        hw_stby_i = 1'b1;
        #1;
        expect_out("R8", 0, 8'h00);
        bus_write(A_DIR, 8'hFF);
        mode_i = 3'd1;
        #1;
        expect_out("R8", 0, 8'h00);
        expect_out("R12", 3, 8'h3C);
        @(negedge clk);
        hw_stby_i = 1'b0; mode_i = 3'd7;
        #1;
        expect_out("R8", 0, 8'h00);
        read_check("R2", A_OUT, 8'hA5);
        bus_write(A_DIR, 8'hF0);
        #1;
        expect_out("R6", 0, 8'hF0);
        expect_out("R6", 1, 8'hA0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule